// File: doc/BRIEF.md
# Serial-Clocked SAR Conversion Sequencer

This block is the digital controller of a 12-bit successive-approximation converter that is read over a three-wire serial link. The link master drives an active-low select and a serial clock. Pulling select low wakes the converter and starts acquisition on the track/hold. Releasing select freezes the sample and starts a conversion, and the conversion is clocked by the serial clock itself. While the result bits are resolved, a 16-bit frame is shifted out. Once the frame is complete, the block drops back into power-down without further command.

An abstract comparator/DAC model inside the block resolves one result bit on each of the first twelve serial-clock rising edges. The analog level is represented by a 12-bit two's-complement code on `ain_code`, which is captured when select rises. Select and serial clock are sampled on the system clock. Every response appears on the outputs one system-clock cycle after the input edge that causes it. The link timing is fixed, so the interface has no handshake and cannot apply back-pressure: the master must supply all sixteen serial clocks to read a result. Taking select low at any point before the last bit aborts the frame and starts a fresh acquisition.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset: `pwr_dn`=1, `sdata_oe`=0, `sdata`=0, `track`=1, `conv_strobe`=0, `frame_cnt`=0, `pstate`=0.
- R2: A falling select edge clears `pwr_dn`, sets `track`=1, `sdata_oe`=0, `frame_cnt`=0 and `pstate`=1 (acquire). The state encoding is 0 = sleep, 1 = acquire, 2 = convert.
- R3: A rising select edge in the acquire state captures `ain_code`, sets `track`=0 and `sdata_oe`=1, drives `sdata`=0 (first leading zero) and sets `pstate`=2.
- R4: The 16-bit frame is four zeros followed by the captured code, MSB first, in two's complement. `sdata` is 0 whenever `sdata_oe` is 0.
- R5: Each serial-clock falling edge during conversion increments `frame_cnt` and presents the next frame bit. The first falling edge presents the second leading zero.
- R6: On the 16th falling edge, `sdata_oe` goes to 0, `pwr_dn` goes to 1, `pstate` goes to 0 and `frame_cnt` reads 16.
- R7: `conv_strobe` pulses for one cycle on each of the first 12 serial-clock rising edges of a frame, and at no other time.
- R8: `track` returns to 1 on the 13th serial-clock rising edge of the frame.
- R9: A falling select edge before the 16th falling edge aborts the frame: `sdata_oe`=0, `track`=1, and the state returns to acquire. The next rising select edge starts a normal frame.
- R10: Serial-clock edges have no effect in sleep or acquire. `pwr_dn` stays 1 until the next falling select edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from link master |
| sclk | input | 1 | Serial clock from link master |
| ain_code | input | RES_W | Two's-complement code standing for the analog input |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Output-driver enable for sdata (0 = high impedance) |
| track | output | 1 | Track/hold control, 1 = track |
| pwr_dn | output | 1 | Power-down flag |
| conv_strobe | output | 1 | One-cycle pulse per resolved result bit |
| frame_cnt | output | CNT_W | Falling edges counted in the current frame |
| pstate | output | 2 | Power state: 0 sleep, 1 acquire, 2 convert |

## Verification
The assertions check on every cycle that the driver is never enabled while powered down, that `sdata` is quiet whenever the driver is off, and that a strobe never occurs while tracking. They also check that `frame_cnt` stays within the frame length, and that select falling or rising produces the state change given in R2, R3 and R9 on the next cycle. Only the bench scenarios can show that the shifted word equals the captured code for corner values (zero, both extremes, alternating patterns). The same holds for the 13th-rise return to track, for aborts at different depths followed by clean frames, and for stray serial clocks being ignored while asleep or acquiring.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PS_SLEEP = 2'd0,
    PS_ACQ   = 2'd1,
    PS_CONV  = 2'd2
  } pstate_e;
endpackage

// File: rtl/adc_edge_det.sv
// Registers a level and reports its edges against the live input.
module adc_edge_det #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic prev,
  output logic rise,
  output logic fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= din;
  end
  assign rise = din & ~prev;
  assign fall = ~din & prev;
endmodule

// File: rtl/adc_cmp_model.sv
// Abstract comparator plus DAC: keeps a trial bit when the held level reaches it.
module adc_cmp_model #(
  parameter int W = 12
) (
  input  logic [W-1:0] held_ob,
  input  logic [W-1:0] trial,
  output logic         keep
);
  assign keep = (held_ob >= trial);
endmodule

// File: rtl/adc_sar_core.sv
// Successive-approximation register, one bit per step, MSB first.
module adc_sar_core #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] sample_in,
  input  logic             step,
  output logic [RES_W-1:0] result
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] SIGN = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] held_ob;
  logic [RES_W-1:0] sar;
  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] trial;
  logic             keep;

  assign trial = sar | (RES_W'(1) << idx);

  adc_cmp_model #(.W(RES_W)) u_cmp (
    .held_ob (held_ob),
    .trial   (trial),
    .keep    (keep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_ob <= '0;
      sar     <= '0;
      idx     <= IDX_W'(RES_W - 1);
    end else if (load) begin
      held_ob <= sample_in ^ SIGN;
      sar     <= '0;
      idx     <= IDX_W'(RES_W - 1);
    end else if (step) begin
      if (keep) sar[idx] <= 1'b1;
      idx <= idx - 1'b1;
    end
  end

  assign result = sar ^ SIGN;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int LEAD_W = 4,
  parameter int FRAME_LEN = RES_W + LEAD_W,
  parameter int CNT_W  = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [RES_W-1:0] ain_code,
  output logic             sdata,
  output logic             sdata_oe,
  output logic             track,
  output logic             pwr_dn,
  output logic             conv_strobe,
  output logic [CNT_W-1:0] frame_cnt,
  output logic [1:0]       pstate
);
  localparam int IDX_W = $clog2(RES_W);
  localparam int RC_W  = $clog2(RES_W + 2);

  pstate_e          st;
  logic             cs_prev, cs_rise, cs_fall;
  logic             sk_prev, sk_rise, sk_fall;
  logic [RC_W-1:0]  rcnt;
  logic [CNT_W-1:0] nxt;
  logic [IDX_W-1:0] bidx;
  logic             nbit;
  logic             step;
  logic             load;
  logic [RES_W-1:0] result;

  adc_edge_det #(.IDLE(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .din(cs_n),
    .prev(cs_prev), .rise(cs_rise), .fall(cs_fall)
  );

  adc_edge_det #(.IDLE(1'b1)) u_sk_edge (
    .clk(clk), .rst_n(rst_n), .din(sclk),
    .prev(sk_prev), .rise(sk_rise), .fall(sk_fall)
  );

  assign load = cs_rise && (st == PS_ACQ);
  assign step = (st == PS_CONV) && !cs_fall && sk_rise && (rcnt < RC_W'(RES_W));

  adc_sar_core #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .load(load),
    .sample_in(ain_code), .step(step), .result(result)
  );

  // Next frame bit: leading zeros, then result MSB first.
  always_comb begin
    nxt  = frame_cnt + 1'b1;
    bidx = IDX_W'(FRAME_LEN - 1 - 32'(nxt));
    nbit = 1'b0;
    if (32'(nxt) >= LEAD_W && 32'(nxt) < FRAME_LEN) nbit = result[bidx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= PS_SLEEP;
      sdata       <= 1'b0;
      sdata_oe    <= 1'b0;
      track       <= 1'b1;
      conv_strobe <= 1'b0;
      frame_cnt   <= '0;
      rcnt        <= '0;
    end else begin
      conv_strobe <= step;
      if (cs_fall) begin
        st        <= PS_ACQ;
        sdata     <= 1'b0;
        sdata_oe  <= 1'b0;
        track     <= 1'b1;
        frame_cnt <= '0;
        rcnt      <= '0;
      end else if (load) begin
        st        <= PS_CONV;
        sdata     <= 1'b0;
        sdata_oe  <= 1'b1;
        track     <= 1'b0;
        frame_cnt <= '0;
        rcnt      <= '0;
      end else if (st == PS_CONV) begin
        if (sk_rise) begin
          if (rcnt <= RC_W'(RES_W)) rcnt <= rcnt + 1'b1;
          if (rcnt == RC_W'(RES_W)) track <= 1'b1;
        end
        if (sk_fall) begin
          frame_cnt <= nxt;
          if (32'(nxt) == FRAME_LEN) begin
            st       <= PS_SLEEP;
            sdata    <= 1'b0;
            sdata_oe <= 1'b0;
          end else begin
            sdata <= nbit;
          end
        end
      end
    end
  end

  assign pwr_dn = (st == PS_SLEEP);
  assign pstate = st;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int FRAME_LEN = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             cs_prev,
  input logic [1:0]       pstate,
  input logic             sdata,
  input logic             sdata_oe,
  input logic             track,
  input logic             pwr_dn,
  input logic             conv_strobe,
  input logic [CNT_W-1:0] frame_cnt
);
  assert_oe_awake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> !pwr_dn);

  assert_quiet_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata);

  assert_strobe_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |-> !track);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frame_cnt) <= FRAME_LEN);

  assert_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_prev && !cs_n) |=> (!pwr_dn && track && !sdata_oe && pstate == 2'd1));

  assert_hold_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_prev && cs_n && pstate == 2'd1) |=> (sdata_oe && !track && !sdata));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && cs_prev && !cs_n) |=> (!sdata_oe && track));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_prev(cs_prev), .pstate(pstate),
  .sdata(sdata), .sdata_oe(sdata_oe), .track(track), .pwr_dn(pwr_dn),
  .conv_strobe(conv_strobe), .frame_cnt(frame_cnt)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] ain = '0;
  logic        sdata, sdata_oe, track, pwr_dn, conv_strobe;
  logic [4:0]  frame_cnt;
  logic [1:0]  pstate;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .ain_code(ain),
    .sdata(sdata), .sdata_oe(sdata_oe), .track(track), .pwr_dn(pwr_dn),
    .conv_strobe(conv_strobe), .frame_cnt(frame_cnt), .pstate(pstate)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: a queue of frame bits and edge counters.
  bit q[$];
  int m_st, m_fc, m_rc;
  bit m_oe, m_sd, m_trk, m_stb, p_cs, p_sk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_fc = 0; m_rc = 0; m_oe = 0; m_sd = 0; m_trk = 1; m_stb = 0;
      p_cs = 1; p_sk = 1; q.delete();
    end else begin
      bit csf, csr, skr, skf;
      csf = p_cs && !cs_n; csr = !p_cs && cs_n;
      skr = !p_sk && sclk; skf = p_sk && !sclk;
      m_stb = 0;
      if (csf) begin
        m_st = 1; m_oe = 0; m_sd = 0; m_trk = 1; m_fc = 0; m_rc = 0; q.delete();
      end else if (csr && m_st == 1) begin
        q.delete();
        for (int i = 0; i < 4; i++) q.push_back(1'b0);
        for (int i = 11; i >= 0; i--) q.push_back(ain[i]);
        m_sd = q.pop_front();
        m_st = 2; m_oe = 1; m_trk = 0; m_fc = 0; m_rc = 0;
      end else if (m_st == 2) begin
        if (skr) begin
          m_rc++;
          if (m_rc <= 12) m_stb = 1;
          if (m_rc == 13) m_trk = 1;
        end
        if (skf) begin
          m_fc++;
          if (q.size() == 0) begin m_st = 0; m_oe = 0; m_sd = 0; end
          else m_sd = q.pop_front();
        end
      end
      p_cs = cs_n; p_sk = sclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sdata_oe == m_oe, "R6 sdata_oe", sdata_oe, m_oe);
      chk(sdata == m_sd, "R4 sdata", sdata, m_sd);
      chk(track == m_trk, "R8 track", track, m_trk);
      chk(pwr_dn == (m_st == 0), "R10 pwr_dn", pwr_dn, m_st == 0);
      chk(conv_strobe == m_stb, "R7 conv_strobe", conv_strobe, m_stb);
      chk(int'(frame_cnt) == m_fc, "R5 frame_cnt", frame_cnt, m_fc);
      chk(int'(pstate) == m_st, "R2 pstate", pstate, m_st);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk(input int n);
    for (int k = 0; k < n; k++) begin
      sclk = 1'b0; wait_n(2);
      sclk = 1'b1; wait_n(2);
    end
  endtask

  task automatic run_frame(input logic [11:0] code, input int nfall, input int acq_clk);
    logic [15:0] got;
    wait_n(1);
    cs_n = 1'b0; ain = code;
    wait_n(1);
    chk(!pwr_dn && track && !sdata_oe, "R2 wake", {pwr_dn, track, sdata_oe}, 3'b010);
    chk(!sdata_oe && track, "R9 idle after select low", {sdata_oe, track}, 2'b01);
    pulse_sclk(acq_clk);
    chk(int'(frame_cnt) == 0 && pstate == 2'd1, "R10 sclk in acquire", frame_cnt, 0);
    cs_n = 1'b1;
    wait_n(1);
    chk(sdata_oe && !track && !sdata, "R3 hold start", {sdata_oe, track, sdata}, 3'b100);
    got = '0;
    got[15] = sdata;
    for (int k = 1; k <= nfall; k++) begin
      sclk = 1'b0; wait_n(1);
      if (k < 16) begin
        got[15-k] = sdata;
        chk(int'(frame_cnt) == k, "R5 count", frame_cnt, k);
      end
      wait_n(1);
      sclk = 1'b1; wait_n(2);
      if (k == 13) chk(track == 1'b1, "R8 track after rise 13", track, 1);
    end
    if (nfall >= 16) begin
      chk(got == {4'b0, code}, "R4 frame word", got, {4'b0, code});
      chk(pwr_dn && !sdata_oe && pstate == 2'd0, "R6 end of frame",
          {pwr_dn, sdata_oe, pstate}, 4'b1000);
      pulse_sclk(3);
      chk(pwr_dn && int'(frame_cnt) == 16, "R10 sclk in sleep", frame_cnt, 16);
    end
  endtask

  initial begin
    wait_n(3);
    chk(pwr_dn && !sdata_oe && !sdata && track && !conv_strobe && frame_cnt == 0 && pstate == 0,
        "R1 reset state", {pwr_dn, sdata_oe, sdata, track}, 4'b1001);
    rst_n = 1'b1;
    wait_n(2);
    chk(pwr_dn && int'(frame_cnt) == 0, "R1 after release", pwr_dn, 1);
    pulse_sclk(2);
    chk(pwr_dn == 1'b1, "R10 sclk before wake", pwr_dn, 1);
    run_frame(12'h000, 16, 0);
    run_frame(12'h7FF, 16, 2);
    run_frame(12'h800, 16, 0);
    run_frame(12'hA5C, 16, 1);
    run_frame(12'h3C5, 7, 0);
    run_frame(12'h001, 16, 0);
    run_frame(12'hFFF, 0, 0);
    run_frame(12'h555, 13, 0);
    run_frame(12'hAAA, 16, 0);
    chk(pwr_dn == 1'b1, "R10 stays asleep", pwr_dn, 1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule